// File: doc/BRIEF.md
# ADC Calibration Mode Sequencer

This block is the control core of a multichannel sigma-delta converter. It keeps an 8-bit mode register and a 3-bit channel select. The mode register holds an operating mode, a gain code, a burnout-current enable and a filter-hold bit. The analog modulator, the coefficient arithmetic and the serial port sit outside the block. They talk to it through three single-cycle handshakes: `conv_done` (the modulator has produced a word), `cal_step_done` (a calibration step has finished) and `rd_done` (the host has read the output word).

Writing a one-shot calibration code to the mode field starts a sequence of one or two steps. The channel code chooses one of three shared coefficient register pairs. At each step the block says whether a zero-scale or a full-scale point is taken and whether the input is internally shorted or external. At the end of each step it pulses a write strobe for the chosen pair. After the last step the mode field clears itself to normal. In background mode a zero-scale slot follows every output word. That slot takes five conversion handshakes, so a word appears once every six. The ready flag (active low) marks that a new word is waiting.

Top module: `adc_cal_sequencer`

## Requirements
- R1: After a synchronous reset, `mode_q` is 0x00, `chan_q` is 3'b100, `drdy` is 1, `cal_pair` is 0, `gain_mult` is 1 and no strobe is active.
- R2: The mode register fields are as follows. Bits [7:5] hold the operating mode, bits [4:2] the gain code g, bit 1 the burnout enable and bit 0 the filter hold. `gain_mult` equals 2^g and `burnout_en` follows bit 1.
- R3: `cal_pair` follows the channel code: 000 and 100 give 0, 001 and 101 give 1, and 010, 011, 110 and 111 give 2.
- R4: Writing a one-shot mode sets `drdy` to 1 on the next cycle. `drdy` stays 1 until the first `conv_done` after the last step. It then drops to 0 and `word_strobe` pulses.
- R5: Mode 001 runs two steps in a fixed order, each ended by `cal_step_done`. The first step is zero-scale on the shorted input and the second is full-scale on the shorted input. Each step gives one `cal_wr_en` pulse, with `cal_wr_full` and `cal_wr_pair` set for that step.
- R6: The other one-shot modes run these steps. 010 runs one zero-scale step on the external input. 011 runs one full-scale step on the external input. 100 runs a zero-scale step on the external input, then a full-scale step on the shorted input. 110 runs one zero-scale step and 111 one full-scale step, both on the shorted input.
- R7: When the last step of a one-shot mode completes, mode bits [7:5] return to 000 without a write. Bits [4:0] keep their values.
- R8: In normal mode (000), `conv_done` clears `drdy` to 0 and pulses `word_strobe`. `rd_done` sets `drdy` back to 1.
- R9: In background mode (101), each output word is followed by a zero-scale slot on the shorted input. The slot takes BG_SLOT_CONVS `conv_done` pulses and then gives one `cal_wr_en` with `cal_wr_full`=0. A full-scale write never occurs in this mode, and the mode field stays 101.
- R10: While filter hold (bit 0) is 1, `conv_done` and `cal_step_done` are ignored and `drdy` never falls. `rd_done` and register writes still take effect.
- R11: A mode write during a calibration aborts it and starts the newly written mode from its first step.
- R12: If a mode write and a final `cal_step_done` arrive in the same cycle, the write wins. No coefficient write occurs and the written mode is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_mode | input | 1 | Mode register write strobe |
| wr_mode_data | input | 8 | Mode register write value |
| wr_chan | input | 1 | Channel select write strobe |
| wr_chan_data | input | 3 | Channel select write value |
| conv_done | input | 1 | Modulator word complete |
| cal_step_done | input | 1 | Current calibration step finished |
| rd_done | input | 1 | Host has read the output word |
| mode_q | output | 8 | Mode register contents |
| chan_q | output | 3 | Channel select contents |
| gain_mult | output | 8 | Decoded gain factor |
| burnout_en | output | 1 | Burnout currents enabled |
| filt_hold | output | 1 | Filter and calibration held in reset |
| drdy | output | 1 | Ready flag, low when a new word waits |
| word_strobe | output | 1 | One-cycle pulse when a new word is posted |
| step_active | output | 1 | A calibration step or background slot is running |
| step_full | output | 1 | Current step is full-scale |
| step_ext | output | 1 | Current step uses the external input |
| cal_pair | output | 2 | Coefficient pair for the current channel |
| cal_wr_en | output | 1 | Coefficient register write pulse |
| cal_wr_full | output | 1 | Pulse updates full-scale (1) or zero-scale (0) |
| cal_wr_pair | output | 2 | Pair being updated |

## Verification
The assertions check on every cycle that:
- the mode field clears after the last step completes;
- `drdy` stays high throughout a one-shot step and never falls while hold is set;
- `word_strobe` only coincides with a low `drdy`;
- background slots never write full-scale;
- the pair code never takes the unused value.

Only the bench's scenarios can show the rest:
- the exact step order of each mode;
- the five-handshake slot length in background mode;
- abort on a mid-sequence write, and a write beating a simultaneous step completion;
- the full channel-to-pair and gain tables.

// File: rtl/acs_pkg.sv
package acs_pkg;
  localparam int MODE_REG_W  = 8;
  localparam int OPMODE_W    = 3;
  localparam int GAIN_CODE_W = 3;
  localparam int GAIN_MULT_W = 1 << GAIN_CODE_W;
  localparam int CHAN_W      = 3;
  localparam int PAIR_W      = 2;

  typedef enum logic [OPMODE_W-1:0] {
    OP_NORMAL    = 3'b000,
    OP_SELF      = 3'b001,
    OP_SYS_ZERO  = 3'b010,
    OP_SYS_FULL  = 3'b011,
    OP_SYS_OFFS  = 3'b100,
    OP_BACKGND   = 3'b101,
    OP_SELF_ZERO = 3'b110,
    OP_SELF_FULL = 3'b111
  } opmode_e;

  typedef struct packed {
    logic full;
    logic ext;
    logic last;
  } step_t;

  function automatic step_t step_of(input logic [OPMODE_W-1:0] code, input logic idx);
    step_t s;
    s = '{full: 1'b0, ext: 1'b0, last: 1'b1};
    case (opmode_e'(code))
      OP_SELF:      s = idx ? '{full: 1'b1, ext: 1'b0, last: 1'b1}
                            : '{full: 1'b0, ext: 1'b0, last: 1'b0};
      OP_SYS_ZERO:  s = '{full: 1'b0, ext: 1'b1, last: 1'b1};
      OP_SYS_FULL:  s = '{full: 1'b1, ext: 1'b1, last: 1'b1};
      OP_SYS_OFFS:  s = idx ? '{full: 1'b1, ext: 1'b0, last: 1'b1}
                            : '{full: 1'b0, ext: 1'b1, last: 1'b0};
      OP_SELF_ZERO: s = '{full: 1'b0, ext: 1'b0, last: 1'b1};
      OP_SELF_FULL: s = '{full: 1'b1, ext: 1'b0, last: 1'b1};
      default:      s = '{full: 1'b0, ext: 1'b0, last: 1'b1};
    endcase
    return s;
  endfunction

  function automatic logic [PAIR_W-1:0] pair_of(input logic [CHAN_W-1:0] ch);
    logic [PAIR_W-1:0] p;
    case (ch)
      3'b000, 3'b100: p = 2'd0;
      3'b001, 3'b101: p = 2'd1;
      default:        p = 2'd2;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/acs_regs.sv
module acs_regs
  import acs_pkg::*;
#(
  parameter logic [MODE_REG_W-1:0] MODE_RST = 8'h00,
  parameter logic [CHAN_W-1:0]     CHAN_RST = 3'b100
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_mode,
  input  logic [MODE_REG_W-1:0] wr_mode_data,
  input  logic                  wr_chan,
  input  logic [CHAN_W-1:0]     wr_chan_data,
  input  logic                  clr_opmode,
  output logic [MODE_REG_W-1:0] mode_q,
  output logic [CHAN_W-1:0]     chan_q
);
  localparam int OP_LSB = MODE_REG_W - OPMODE_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_RST;
    end else if (wr_mode) begin
      mode_q <= wr_mode_data;
    end else if (clr_opmode) begin
      mode_q[MODE_REG_W-1:OP_LSB] <= OP_NORMAL;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) chan_q <= CHAN_RST;
    else if (wr_chan) chan_q <= wr_chan_data;
  end

  // R7
  opmode_autoclear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_opmode && !wr_mode) |=> (mode_q[MODE_REG_W-1:OP_LSB] == OP_NORMAL));

  // R12
  write_wins_chk: assert property (@(posedge clk) disable iff (rst)
    wr_mode |=> (mode_q == $past(wr_mode_data)));
endmodule

// File: rtl/acs_decode.sv
module acs_decode
  import acs_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic [CHAN_W-1:0]      chan_q,
  input  logic [GAIN_CODE_W-1:0] gain_code,
  output logic [PAIR_W-1:0]      cal_pair,
  output logic [GAIN_MULT_W-1:0] gain_mult
);
  always_comb cal_pair = pair_of(chan_q);

  for (genvar i = 0; i < GAIN_MULT_W; i++) begin : g_gain
    assign gain_mult[i] = (gain_code == GAIN_CODE_W'(i));
  end

  // R3
  pair_range_chk: assert property (@(posedge clk) disable iff (rst)
    cal_pair != 2'b11);

  // R2
  gain_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(gain_mult) == 1);
endmodule

// File: rtl/acs_seq.sv
module acs_seq
  import acs_pkg::*;
#(
  parameter int BG_SLOT_CONVS = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_mode,
  input  logic [OPMODE_W-1:0] wr_code,
  input  logic [OPMODE_W-1:0] cur_code,
  input  logic                hold,
  input  logic                conv_done,
  input  logic                cal_step_done,
  input  logic                rd_done,
  input  logic [PAIR_W-1:0]   cal_pair,
  output logic                clr_opmode,
  output logic                drdy,
  output logic                word_strobe,
  output logic                step_active,
  output logic                step_full,
  output logic                step_ext,
  output logic                cal_wr_en,
  output logic                cal_wr_full,
  output logic [PAIR_W-1:0]   cal_wr_pair
);
  localparam int CNT_W = (BG_SLOT_CONVS < 2) ? 1 : $clog2(BG_SLOT_CONVS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BG_SLOT_CONVS - 1);

  typedef enum logic [2:0] {
    S_NORM, S_CAL, S_WAIT, S_BGCONV, S_BGSLOT
  } state_e;

  state_e            state;
  logic              idx;
  logic [CNT_W-1:0]  slot_cnt;
  step_t             cur_step;

  always_comb cur_step = step_of(cur_code, idx);

  always_comb begin
    clr_opmode  = !wr_mode && !hold && (state == S_CAL) && cal_step_done && cur_step.last;
    step_active = (state == S_CAL) || (state == S_BGSLOT);
    step_full   = (state == S_CAL) && cur_step.full;
    step_ext    = (state == S_CAL) && cur_step.ext;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_NORM;
      idx         <= 1'b0;
      slot_cnt    <= '0;
      drdy        <= 1'b1;
      word_strobe <= 1'b0;
      cal_wr_en   <= 1'b0;
      cal_wr_full <= 1'b0;
      cal_wr_pair <= '0;
    end else begin
      word_strobe <= 1'b0;
      cal_wr_en   <= 1'b0;
      if (rd_done) drdy <= 1'b1;
      if (wr_mode) begin
        idx      <= 1'b0;
        slot_cnt <= '0;
        case (opmode_e'(wr_code))
          OP_NORMAL:  state <= S_NORM;
          OP_BACKGND: state <= S_BGCONV;
          default: begin
            state <= S_CAL;
            drdy  <= 1'b1;
          end
        endcase
      end else if (!hold) begin
        case (state)
          S_NORM, S_BGCONV: begin
            if (conv_done) begin
              drdy        <= 1'b0;
              word_strobe <= 1'b1;
              if (state == S_BGCONV) begin
                state    <= S_BGSLOT;
                slot_cnt <= '0;
              end
            end
          end
          S_BGSLOT: begin
            if (conv_done) begin
              if (slot_cnt == CNT_LAST) begin
                cal_wr_en   <= 1'b1;
                cal_wr_full <= 1'b0;
                cal_wr_pair <= cal_pair;
                state       <= S_BGCONV;
              end else begin
                slot_cnt <= slot_cnt + 1'b1;
              end
            end
          end
          S_CAL: begin
            if (cal_step_done) begin
              cal_wr_en   <= 1'b1;
              cal_wr_full <= cur_step.full;
              cal_wr_pair <= cal_pair;
              if (cur_step.last) state <= S_WAIT;
              else idx <= 1'b1;
            end
          end
          S_WAIT: begin
            if (conv_done) begin
              drdy        <= 1'b0;
              word_strobe <= 1'b1;
              state       <= S_NORM;
            end
          end
          default: state <= S_NORM;
        endcase
      end
    end
  end

  // R4
  cal_drdy_high_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_CAL) |-> drdy);

  // R10
  hold_no_fall_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> !$fell(drdy));

  // R8
  strobe_drdy_chk: assert property (@(posedge clk) disable iff (rst)
    word_strobe |-> !drdy);

  // R9
  bg_zero_only_chk: assert property (@(posedge clk) disable iff (rst)
    (cal_wr_en && state == S_BGCONV) |-> !cal_wr_full);
endmodule

// File: rtl/adc_cal_sequencer.sv
module adc_cal_sequencer
  import acs_pkg::*;
#(
  parameter int                    BG_SLOT_CONVS = 5,
  parameter logic [MODE_REG_W-1:0] MODE_RST      = 8'h00,
  parameter logic [CHAN_W-1:0]     CHAN_RST      = 3'b100
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_mode,
  input  logic [MODE_REG_W-1:0]  wr_mode_data,
  input  logic                   wr_chan,
  input  logic [CHAN_W-1:0]      wr_chan_data,
  input  logic                   conv_done,
  input  logic                   cal_step_done,
  input  logic                   rd_done,
  output logic [MODE_REG_W-1:0]  mode_q,
  output logic [CHAN_W-1:0]      chan_q,
  output logic [GAIN_MULT_W-1:0] gain_mult,
  output logic                   burnout_en,
  output logic                   filt_hold,
  output logic                   drdy,
  output logic                   word_strobe,
  output logic                   step_active,
  output logic                   step_full,
  output logic                   step_ext,
  output logic [PAIR_W-1:0]      cal_pair,
  output logic                   cal_wr_en,
  output logic                   cal_wr_full,
  output logic [PAIR_W-1:0]      cal_wr_pair
);
  localparam int OP_LSB   = MODE_REG_W - OPMODE_W;
  localparam int GAIN_LSB = OP_LSB - GAIN_CODE_W;

  logic clr_opmode;

  acs_regs #(.MODE_RST(MODE_RST), .CHAN_RST(CHAN_RST)) u_regs (
    .clk(clk), .rst(rst),
    .wr_mode(wr_mode), .wr_mode_data(wr_mode_data),
    .wr_chan(wr_chan), .wr_chan_data(wr_chan_data),
    .clr_opmode(clr_opmode),
    .mode_q(mode_q), .chan_q(chan_q)
  );

  acs_decode u_dec (
    .clk(clk), .rst(rst),
    .chan_q(chan_q),
    .gain_code(mode_q[OP_LSB-1:GAIN_LSB]),
    .cal_pair(cal_pair),
    .gain_mult(gain_mult)
  );

  acs_seq #(.BG_SLOT_CONVS(BG_SLOT_CONVS)) u_seq (
    .clk(clk), .rst(rst),
    .wr_mode(wr_mode),
    .wr_code(wr_mode_data[MODE_REG_W-1:OP_LSB]),
    .cur_code(mode_q[MODE_REG_W-1:OP_LSB]),
    .hold(filt_hold),
    .conv_done(conv_done), .cal_step_done(cal_step_done), .rd_done(rd_done),
    .cal_pair(cal_pair),
    .clr_opmode(clr_opmode),
    .drdy(drdy), .word_strobe(word_strobe),
    .step_active(step_active), .step_full(step_full), .step_ext(step_ext),
    .cal_wr_en(cal_wr_en), .cal_wr_full(cal_wr_full), .cal_wr_pair(cal_wr_pair)
  );

  assign burnout_en = mode_q[1];
  assign filt_hold  = mode_q[0];

  // R10
  hold_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (filt_hold && !wr_mode) |=> !cal_wr_en);
endmodule

// File: tb/tb_adc_cal_sequencer.sv
module tb_adc_cal_sequencer;
  logic       clk = 1'b0;
  logic       rst;
  logic       wr_mode = 1'b0;
  logic [7:0] wr_mode_data = '0;
  logic       wr_chan = 1'b0;
  logic [2:0] wr_chan_data = '0;
  logic       conv_done = 1'b0;
  logic       cal_step_done = 1'b0;
  logic       rd_done = 1'b0;
  logic [7:0] mode_q, gain_mult;
  logic [2:0] chan_q;
  logic       burnout_en, filt_hold, drdy, word_strobe;
  logic       step_active, step_full, step_ext;
  logic [1:0] cal_pair, cal_wr_pair;
  logic       cal_wr_en, cal_wr_full;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  adc_cal_sequencer dut (.*);

  task automatic chk(input string req, input string what, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // drive strobes after a falling edge, let one rising edge pass, sample at the next falling edge
  task automatic step_cycle();
    @(posedge clk);
    @(negedge clk);
    wr_mode = 0; wr_chan = 0; conv_done = 0; cal_step_done = 0; rd_done = 0;
  endtask

  task automatic put_mode(input logic [7:0] v);
    wr_mode = 1; wr_mode_data = v; step_cycle();
  endtask
  task automatic put_chan(input logic [2:0] v);
    wr_chan = 1; wr_chan_data = v; step_cycle();
  endtask
  task automatic pulse_conv();  conv_done = 1;     step_cycle(); endtask
  task automatic pulse_step();  cal_step_done = 1; step_cycle(); endtask
  task automatic pulse_rd();    rd_done = 1;       step_cycle(); endtask

  task automatic t_reset();
    chk("R1", "mode", mode_q, 8'h00);
    chk("R1", "chan", chan_q, 3'b100);
    chk("R1", "drdy", drdy, 1);
    chk("R1", "pair", cal_pair, 0);
    chk("R1", "gain", gain_mult, 1);
    chk("R1", "wr_en", cal_wr_en, 0);
  endtask

  task automatic t_fields();
    for (int g = 0; g < 8; g++) begin
      put_mode(8'((g << 2) | ((g & 1) << 1)));
      chk("R2", "gain_mult", gain_mult, 1 << g);
      chk("R2", "burnout", burnout_en, g & 1);
    end
    put_mode(8'h00);
  endtask

  task automatic t_pairs();
    for (int c = 0; c < 8; c++) begin
      int exp;
      exp = (c == 0 || c == 4) ? 0 : (c == 1 || c == 5) ? 1 : 2;
      put_chan(3'(c));
      chk("R3", "pair", cal_pair, exp);
    end
  endtask

  task automatic t_normal();
    put_mode(8'h00);
    pulse_conv();
    chk("R8", "drdy low", drdy, 0);
    chk("R8", "strobe", word_strobe, 1);
    step_cycle();
    chk("R8", "strobe one cycle", word_strobe, 0);
    pulse_rd();
    chk("R8", "drdy high", drdy, 1);
  endtask

  task automatic t_selfcal();
    put_chan(3'b000);
    pulse_conv();
    put_mode(8'h20);
    chk("R4", "drdy set", drdy, 1);
    chk("R5", "active", step_active, 1);
    chk("R5", "first zero", step_full, 0);
    chk("R5", "first int", step_ext, 0);
    pulse_step();
    chk("R5", "wr1", cal_wr_en, 1);
    chk("R5", "wr1 zero", cal_wr_full, 0);
    chk("R5", "wr1 pair", cal_wr_pair, 0);
    chk("R5", "second full", step_full, 1);
    chk("R7", "mode held mid", mode_q, 8'h20);
    pulse_step();
    chk("R5", "wr2", cal_wr_en, 1);
    chk("R5", "wr2 full", cal_wr_full, 1);
    chk("R7", "mode cleared", mode_q, 8'h00);
    chk("R4", "drdy still high", drdy, 1);
    chk("R5", "inactive", step_active, 0);
    pulse_conv();
    chk("R4", "drdy low", drdy, 0);
    chk("R4", "strobe", word_strobe, 1);
  endtask

  task automatic t_sysoffs();
    put_chan(3'b101);
    put_mode(8'h80);
    chk("R6", "100 s1 ext", step_ext, 1);
    chk("R6", "100 s1 zero", step_full, 0);
    pulse_step();
    chk("R6", "100 wr pair", cal_wr_pair, 1);
    chk("R6", "100 s2 int", step_ext, 0);
    chk("R6", "100 s2 full", step_full, 1);
    pulse_step();
    chk("R6", "100 wr2 full", cal_wr_full, 1);
    chk("R7", "100 cleared", mode_q, 8'h00);
    put_mode(8'h4E);
    chk("R6", "010 ext", step_ext, 1);
    chk("R6", "010 zero", step_full, 0);
    chk("R2", "010 gain", gain_mult, 8);
    pulse_step();
    chk("R6", "010 wr zero", cal_wr_full, 0);
    chk("R7", "fields kept", mode_q, 8'h0E);
    put_mode(8'h60);
    chk("R6", "011 ext full", {step_ext, step_full}, 3);
    pulse_step();
    chk("R7", "011 cleared", mode_q, 8'h00);
    put_mode(8'hC0);
    chk("R6", "110 int zero", {step_ext, step_full}, 0);
    pulse_step();
    chk("R6", "110 wr zero", {cal_wr_en, cal_wr_full}, 2);
    put_mode(8'hE0);
    chk("R6", "111 int full", {step_ext, step_full}, 1);
    pulse_step();
    chk("R6", "111 wr full", {cal_wr_en, cal_wr_full}, 3);
  endtask

  task automatic t_background();
    int words;
    put_chan(3'b010);
    put_mode(8'hA0);
    chk("R9", "bg idle", step_active, 0);
    pulse_conv();
    chk("R9", "word", word_strobe, 1);
    chk("R9", "slot", step_active, 1);
    pulse_rd();
    for (int i = 0; i < 4; i++) begin
      pulse_conv();
      chk("R9", "no early wr", cal_wr_en, 0);
      chk("R9", "no word in slot", word_strobe, 0);
    end
    pulse_conv();
    chk("R9", "slot wr", cal_wr_en, 1);
    chk("R9", "slot zero", cal_wr_full, 0);
    chk("R9", "slot pair", cal_wr_pair, 2);
    chk("R9", "mode kept", mode_q, 8'hA0);
    words = 0;
    for (int i = 0; i < 12; i++) begin
      pulse_conv();
      if (word_strobe) words++;
      if (cal_wr_en) chk("R9", "never full", cal_wr_full, 0);
    end
    chk("R9", "word rate", words, 2);
  endtask

  task automatic t_hold();
    put_mode(8'h00);
    pulse_conv();
    put_mode(8'h01);
    chk("R10", "drdy stays low", drdy, 0);
    pulse_conv();
    chk("R10", "no word", word_strobe, 0);
    pulse_rd();
    chk("R10", "rd works", drdy, 1);
    pulse_conv();
    chk("R10", "drdy kept", drdy, 1);
    put_mode(8'h21);
    pulse_step();
    chk("R10", "step ignored", cal_wr_en, 0);
    chk("R10", "still zero step", step_full, 0);
    put_mode(8'h20);
    pulse_step();
    chk("R10", "resumed", cal_wr_en, 1);
    pulse_step();
    pulse_conv();
  endtask

  task automatic t_abort();
    put_mode(8'h20);
    pulse_step();
    put_mode(8'hE0);
    chk("R11", "new mode", mode_q, 8'hE0);
    chk("R11", "restart full", step_full, 1);
    pulse_step();
    chk("R11", "wr full", cal_wr_full, 1);
    chk("R11", "cleared", mode_q, 8'h00);
    put_mode(8'h40);
    wr_mode = 1; wr_mode_data = 8'h60; cal_step_done = 1; step_cycle();
    chk("R12", "no wr", cal_wr_en, 0);
    chk("R12", "mode kept", mode_q, 8'h60);
    chk("R12", "new step", {step_ext, step_full}, 3);
  endtask

  initial begin
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    t_reset();
    t_fields();
    t_pairs();
    t_normal();
    t_selfcal();
    t_sysoffs();
    t_background();
    t_hold();
    t_abort();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule